// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

This block turns an interprocessor interrupt command into a set of receiving targets among `N_TGT` interrupt controllers. The command arrives as two 32-bit words. The low word carries the vector, the delivery mode, the destination mode, a pending flag and the shorthand. The high word carries the 8-bit destination in its top byte. Each target presents four values: its physical ID, its 8-bit logical ID, the 4-bit mode nibble of its destination-format register, and an enable flag. The sender is identified by `src_idx`.

For each target the block works out whether it is addressed, either by shorthand or by a physical or logical destination. In lowest-priority delivery it narrows that set to exactly one enabled target. It does this with a rotating pointer that persists from one command to the next. The result is registered and presented as a delivery mask, together with the vector and sanitised copies of both command words. Acceptance of the interrupt at each target is handled elsewhere.

The control is a two-state machine. `S_IDLE` means no result is being presented. `S_EMIT` presents the result of the command strobed on the previous edge. The transitions are:
- `IDLE_TO_EMIT` on `cmd_valid`.
- `EMIT_TO_EMIT` on `cmd_valid` back to back.
- `EMIT_TO_IDLE` when no strobe is present.

Top module: `ipi_dest_resolver`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `cmd_valid` is high, and is low otherwise. After reset `out_valid` is 0 and `out_mask` is all zeros.
- R2: The shorthand is `cmd_lo[19:18]`. The encodings are:
  - 00: no shorthand; the destination is used.
  - 01: the sender only (`src_idx`).
  - 10: every target.
  - 11: every target except the sender.
- R3: With no shorthand and `cmd_lo[11]`=0 (physical mode), a target is hit when the destination `cmd_hi[31:24]` equals 0xFF or equals that target's physical ID.
- R4: With no shorthand, `cmd_lo[11]`=1 (logical mode), and a target format nibble of 0xF (flat), the target is hit when (logical ID AND destination) is nonzero.
- R5: With no shorthand, logical mode, and a format nibble of 0x0 (cluster), the target is hit when the upper nibbles of the logical ID and the destination are equal and the AND of their lower nibbles is nonzero. Any other format nibble value never hits in logical mode.
- R6: When the delivery mode `cmd_lo[10:8]` is 001 (lowest priority), the mask has at most one bit set. That bit is the first target after the previously chosen one, wrapping at `N_TGT`, that is both hit and enabled. The pointer then moves to the chosen target.
- R7: After reset the pointer is at target `N_TGT-1`, so the first lowest-priority search starts at target 0.
- R8: In lowest-priority mode, if no hit target is enabled, the mask is all zeros and the pointer is left unchanged.
- R9: `out_cmd_lo` is `cmd_lo` with bit 12 (pending) cleared. `out_vector` is `cmd_lo[7:0]` and `out_dmode` is `cmd_lo[10:8]`.
- R10: `out_cmd_hi` keeps `cmd_hi[31:24]`, and its bits 23:0 are zero.
- R11: In any delivery mode other than 001, the mask is the full hit set, whatever the enable flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_lo | input | 32 | Low command word |
| cmd_hi | input | 32 | High command word, destination in bits 31:24 |
| src_idx | input | IW | Index of the sending target |
| tgt_phys_id | input | N_TGT*8 | Physical ID per target, target i in bits 8i+7:8i |
| tgt_log_id | input | N_TGT*8 | Logical ID per target |
| tgt_fmt | input | N_TGT*4 | Destination-format mode nibble per target |
| tgt_en | input | N_TGT | Target enabled flag |
| out_valid | output | 1 | Result present |
| out_mask | output | N_TGT | Delivery mask, bit i for target i |
| out_vector | output | 8 | Interrupt vector |
| out_dmode | output | 3 | Delivery mode |
| out_cmd_lo | output | 32 | Low word with the pending bit cleared |
| out_cmd_hi | output | 32 | High word with bits 23:0 cleared |

## Verification
Every result is due one clock edge after the strobe. The mask, vector and command copies are captured on the edge that samples `cmd_valid`, and `out_valid` rises in that same cycle and falls one edge later unless another strobe follows. The bench drives each command on a falling edge and holds the strobe for one cycle. It reads the outputs on the next falling edge, which is half a cycle after the capturing edge, and then looks one more falling edge later to confirm that `out_valid` has dropped. The rotating pointer changes on the same capturing edge, so a sequence of back-to-back lowest-priority commands checks each successive choice at its own falling edge.

// File: rtl/ipi_res_pkg.sv
package ipi_res_pkg;
    localparam int DEST_W = 8;
    localparam logic [DEST_W-1:0] DEST_BCAST  = 8'hFF;
    localparam logic [2:0]        DM_LOWEST   = 3'b001;
    localparam logic [3:0]        FMT_FLAT    = 4'hF;
    localparam logic [3:0]        FMT_CLUSTER = 4'h0;
    localparam int PEND_BIT = 12;

    typedef enum logic [1:0] {
        SH_NONE   = 2'b00,
        SH_SELF   = 2'b01,
        SH_ALL    = 2'b10,
        SH_OTHERS = 2'b11
    } shorthand_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } res_state_e;
endpackage

// File: rtl/ipi_tgt_match.sv
module ipi_tgt_match
    import ipi_res_pkg::*;
(
    input  shorthand_e        shorthand,
    input  logic              logical,
    input  logic [DEST_W-1:0] dest,
    input  logic              is_self,
    input  logic [DEST_W-1:0] phys_id,
    input  logic [DEST_W-1:0] log_id,
    input  logic [3:0]        fmt,
    output logic              hit
);
    logic phys_hit;
    logic log_hit;

    assign phys_hit = (dest == DEST_BCAST) || (dest == phys_id);

    always_comb begin
        log_hit = 1'b0;
        if (fmt == FMT_FLAT)
            log_hit = |(log_id & dest);
        else if (fmt == FMT_CLUSTER)
            log_hit = (log_id[7:4] == dest[7:4]) && (|(log_id[3:0] & dest[3:0]));
    end

    always_comb begin
        unique case (shorthand)
            SH_NONE:   hit = logical ? log_hit : phys_hit;
            SH_SELF:   hit = is_self;
            SH_ALL:    hit = 1'b1;
            SH_OTHERS: hit = !is_self;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
    parameter int N_TGT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TGT-1:0] cand,
    input  logic             commit,
    output logic [N_TGT-1:0] grant
);
    localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1;

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] pick_idx;
    logic          found;

    always_comb begin
        found    = 1'b0;
        pick_idx = ptr_q;
        grant    = '0;
        for (int k = 1; k <= N_TGT; k++) begin
            int j;
            j = (int'(ptr_q) + k) % N_TGT;
            if (!found && cand[j]) begin
                found    = 1'b1;
                pick_idx = IW'(j);
                grant[j] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= IW'(N_TGT - 1);
        else if (commit && found)
            ptr_q <= pick_idx;
    end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_res_pkg::*;
#(
    parameter int N_TGT = 8,
    localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [31:0]             cmd_lo,
    input  logic [31:0]             cmd_hi,
    input  logic [IW-1:0]           src_idx,
    input  logic [N_TGT*DEST_W-1:0] tgt_phys_id,
    input  logic [N_TGT*DEST_W-1:0] tgt_log_id,
    input  logic [N_TGT*4-1:0]      tgt_fmt,
    input  logic [N_TGT-1:0]        tgt_en,
    output logic                    out_valid,
    output logic [N_TGT-1:0]        out_mask,
    output logic [7:0]              out_vector,
    output logic [2:0]              out_dmode,
    output logic [31:0]             out_cmd_lo,
    output logic [31:0]             out_cmd_hi
);
    res_state_e state_q, state_d;

    shorthand_e        sh;
    logic              logical;
    logic [2:0]        dmode;
    logic [DEST_W-1:0] dest;
    logic              lowest;
    logic [N_TGT-1:0]  hit;
    logic [N_TGT-1:0]  cand;
    logic [N_TGT-1:0]  grant;
    logic [N_TGT-1:0]  next_mask;
    logic [23:0]       unused_hi;

    assign sh        = shorthand_e'(cmd_lo[19:18]);
    assign logical   = cmd_lo[11];
    assign dmode     = cmd_lo[10:8];
    assign dest      = cmd_hi[31:24];
    assign unused_hi = cmd_hi[23:0];
    assign lowest    = (dmode == DM_LOWEST);

    for (genvar g = 0; g < N_TGT; g++) begin : g_match
        ipi_tgt_match u_m (
            .shorthand (sh),
            .logical   (logical),
            .dest      (dest),
            .is_self   (src_idx == IW'(g)),
            .phys_id   (tgt_phys_id[g*DEST_W +: DEST_W]),
            .log_id    (tgt_log_id[g*DEST_W +: DEST_W]),
            .fmt       (tgt_fmt[g*4 +: 4]),
            .hit       (hit[g])
        );
    end

    assign cand = hit & tgt_en;

    ipi_rr_pick #(.N_TGT(N_TGT)) u_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand   (cand),
        .commit (cmd_valid && lowest),
        .grant  (grant)
    );

    assign next_mask = lowest ? grant : hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_valid) state_d = S_EMIT;
            S_EMIT:  state_d = cmd_valid ? S_EMIT : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_mask   <= '0;
            out_cmd_lo <= '0;
            out_cmd_hi <= '0;
        end else if (cmd_valid) begin
            out_mask   <= next_mask;
            out_cmd_lo <= cmd_lo & ~(32'h1 << PEND_BIT);
            out_cmd_hi <= {dest, 24'h0};
        end
    end

    assign out_valid  = (state_q == S_EMIT);
    assign out_vector = out_cmd_lo[7:0];
    assign out_dmode  = out_cmd_lo[10:8];
endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
    parameter int N_TGT = 8,
    parameter int IW = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [31:0]      cmd_lo,
    input logic [IW-1:0]    src_idx,
    input logic             out_valid,
    input logic [N_TGT-1:0] out_mask,
    input logic [2:0]       out_dmode,
    input logic [31:0]      out_cmd_lo,
    input logic [31:0]      out_cmd_hi
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !out_valid);
    // R6
    lp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dmode == 3'b001) |-> $onehot0(out_mask));
    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_cmd_lo[12]);
    // R9
    vec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> out_cmd_lo[7:0] == $past(cmd_lo[7:0]));
    // R10
    hi_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cmd_hi[23:0] == 24'h0);
    // R2
    self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lo[19:18] == 2'b01 && cmd_lo[10:8] != 3'b001)
        |=> out_mask == (N_TGT'(1) << $past(src_idx)));
endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N_TGT(N_TGT), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_lo     (cmd_lo),
    .src_idx    (src_idx),
    .out_valid  (out_valid),
    .out_mask   (out_mask),
    .out_dmode  (out_dmode),
    .out_cmd_lo (out_cmd_lo),
    .out_cmd_hi (out_cmd_hi)
);

// File: tb/sim_ipi_dest_resolver.sv
`timescale 1ns/1ps
module sim_ipi_dest_resolver;
    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [31:0]   cmd_lo = '0;
    logic [31:0]   cmd_hi = '0;
    logic [IW-1:0] src_idx = '0;
    logic [N*8-1:0] tgt_phys_id, tgt_log_id;
    logic [N*4-1:0] tgt_fmt;
    logic [N-1:0]   tgt_en;
    logic           out_valid;
    logic [N-1:0]   out_mask;
    logic [7:0]     out_vector;
    logic [2:0]     out_dmode;
    logic [31:0]    out_cmd_lo, out_cmd_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ipi_dest_resolver #(.N_TGT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_lo(cmd_lo),
        .cmd_hi(cmd_hi), .src_idx(src_idx), .tgt_phys_id(tgt_phys_id),
        .tgt_log_id(tgt_log_id), .tgt_fmt(tgt_fmt), .tgt_en(tgt_en),
        .out_valid(out_valid), .out_mask(out_mask), .out_vector(out_vector),
        .out_dmode(out_dmode), .out_cmd_lo(out_cmd_lo), .out_cmd_hi(out_cmd_hi)
    );

    function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] dm,
                                          input logic lg, input logic [1:0] sh);
        return {12'h0, sh, 5'h0, 1'b1, lg, dm, vec};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] lo, input logic [7:0] d, input logic [IW-1:0] s);
        @(negedge clk);
        cmd_lo = lo; cmd_hi = {d, 24'hABCDEF}; src_idx = s; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset mask", 64'(out_mask), 64'd0);
    endtask

    task automatic t_timing;
        send(mk_lo(8'h40, 3'b000, 1'b0, 2'b00), 8'h12, 3'd0);
        chk("R1 valid after strobe", 64'(out_valid), 64'd1);
        chk("R3 phys id match", 64'(out_mask), 64'h04);
        @(negedge clk);
        chk("R1 valid drops", 64'(out_valid), 64'd0);
    endtask

    task automatic t_short;
        send(mk_lo(8'h41, 3'b000, 1'b0, 2'b01), 8'h00, 3'd5);
        chk("R2 self", 64'(out_mask), 64'h20);
        send(mk_lo(8'h42, 3'b000, 1'b0, 2'b10), 8'h00, 3'd5);
        chk("R2 all incl", 64'(out_mask), 64'hFF);
        send(mk_lo(8'h43, 3'b000, 1'b1, 2'b11), 8'h00, 3'd2);
        chk("R2 all excl", 64'(out_mask), 64'hFB);
    endtask

    task automatic t_phys;
        send(mk_lo(8'h50, 3'b000, 1'b0, 2'b00), 8'hFF, 3'd0);
        chk("R3 broadcast", 64'(out_mask), 64'hFF);
        send(mk_lo(8'h51, 3'b000, 1'b0, 2'b00), 8'h30, 3'd0);
        chk("R3 no id", 64'(out_mask), 64'h00);
    endtask

    task automatic t_flat;
        for (int i = 0; i < N; i++) begin
            tgt_log_id[i*8 +: 8] = 8'(1 << i);
            tgt_fmt[i*4 +: 4] = 4'hF;
        end
        send(mk_lo(8'h60, 3'b000, 1'b1, 2'b00), 8'h0A, 3'd0);
        chk("R4 flat", 64'(out_mask), 64'h0A);
        send(mk_lo(8'h61, 3'b000, 1'b1, 2'b00), 8'h00, 3'd0);
        chk("R4 flat zero", 64'(out_mask), 64'h00);
    endtask

    task automatic t_cluster;
        for (int i = 0; i < N; i++) begin
            tgt_log_id[i*8 +: 8] = {4'(i / 4 + 1), 4'(1 << (i % 4))};
            tgt_fmt[i*4 +: 4] = 4'h0;
        end
        send(mk_lo(8'h70, 3'b000, 1'b1, 2'b00), 8'h25, 3'd0);
        chk("R5 cluster", 64'(out_mask), 64'h50);
        tgt_fmt[6*4 +: 4] = 4'h5;
        send(mk_lo(8'h71, 3'b000, 1'b1, 2'b00), 8'h25, 3'd0);
        chk("R5 bad format", 64'(out_mask), 64'h10);
    endtask

    task automatic t_fields;
        send(mk_lo(8'h9C, 3'b100, 1'b0, 2'b00), 8'h11, 3'd0);
        chk("R9 pending cleared", 64'(out_cmd_lo), 64'h0000_049C);
        chk("R9 vector", 64'(out_vector), 64'h9C);
        chk("R9 dmode", 64'(out_dmode), 64'h4);
        chk("R10 high word", 64'(out_cmd_hi), 64'h1100_0000);
    endtask

    task automatic t_fixed_en;
        tgt_en = 8'h0F;
        send(mk_lo(8'h80, 3'b000, 1'b0, 2'b00), 8'hFF, 3'd0);
        chk("R11 enable ignored", 64'(out_mask), 64'hFF);
    endtask

    task automatic t_lowest;
        logic [31:0] lp;
        lp = mk_lo(8'hA0, 3'b001, 1'b0, 2'b00);
        tgt_en = 8'hFF;
        send(lp, 8'hFF, 3'd0);
        chk("R7 first pick", 64'(out_mask), 64'h01);
        send(lp, 8'hFF, 3'd0);
        chk("R6 next pick", 64'(out_mask), 64'h02);
        tgt_en = 8'h84;
        send(lp, 8'hFF, 3'd0);
        chk("R6 skip disabled", 64'(out_mask), 64'h04);
        send(lp, 8'hFF, 3'd0);
        chk("R6 pick 7", 64'(out_mask), 64'h80);
        send(lp, 8'hFF, 3'd0);
        chk("R6 wrap", 64'(out_mask), 64'h04);
        tgt_en = 8'hF7;
        send(lp, 8'h13, 3'd0);
        chk("R8 none enabled", 64'(out_mask), 64'h00);
        tgt_en = 8'hFF;
        send(lp, 8'hFF, 3'd0);
        chk("R8 pointer kept", 64'(out_mask), 64'h08);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            tgt_phys_id[i*8 +: 8] = 8'(8'h10 + i);
            tgt_log_id[i*8 +: 8]  = 8'h00;
            tgt_fmt[i*4 +: 4]     = 4'hF;
        end
        tgt_en = 8'hFF;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_timing;
        t_short;
        t_phys;
        t_flat;
        t_cluster;
        t_fields;
        t_fixed_en;
        t_lowest;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule